// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block merges eleven status event lines from a memory controller into a single interrupt request for a processor. Each line can be allowed or blocked by its bit in an enable register. An allowed line that goes from low to high sets a pending flag, and the interrupt output is the registered OR of all pending flags. The processor reaches the block through a simple single-cycle read/write register port.

The interrupt can be dropped in two ways. The first is an explicit write with bit 0 set to the write-only clear register at offset 0x158. The second happens when the processor has not cleared the interrupt and ordinary bus traffic continues: any later read, or any write to another address, drops the interrupt. In both cases a new allowed event edge in the same cycle takes priority, and the interrupt stays asserted.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_o` is low and the enable register (offset 0x150) reads as zero.
- R2: A write to offset 0x150 loads bits [10:0] of the write data into the enable register. A read of 0x150 returns that value in bits [10:0], with bits [31:11] read as zero. Upper write-data bits are discarded.
- R3: When event line i rises while enable bit i is set, `irq_o` is high after the next rising clock edge.
- R4: A rising edge on a line whose enable bit is clear is not remembered. Setting the enable bit later, while the line is still high, does not raise `irq_o`.
- R5: A line that stays high produces only one interrupt. After a clear, `irq_o` stays low while that line remains high.
- R6: A write to offset 0x158 with data bit 0 set drops `irq_o` after that clock edge, provided no allowed event rises in the same cycle.
- R7: Data bits 1 and 2 of a write to 0x158 have no effect. A write to 0x158 with bit 0 clear leaves `irq_o` unchanged.
- R8: An allowed event edge in the same cycle as a clear write, or as a self-clearing bus access, keeps `irq_o` high.
- R9: Any read, or any write to an address other than 0x158, drops `irq_o` after that edge, provided no allowed event rises in the same cycle.
- R10: While there is no bus access and no clear, a high `irq_o` stays high.
- R11: Reads of offset 0x158 and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 11 | Status event lines, one per source |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an allowed event edge that lands in exactly the same clock cycle as a clear write or a self-clearing read. The bench reaches it by raising an event line and the bus strobe in the same drive step. It does this for a line that is not yet pending and also for a line that is pending again after a fall. A level held through a clear, and an event that rises while masked before being enabled, are set up the same way.

// File: rtl/sirq_pkg.sv
// Package: default sizes, register offsets and the command record passed
// from the register port to the pending bank.
package sirq_pkg;
    localparam int unsigned SIRQ_N_EVT   = 11;
    localparam int unsigned SIRQ_ADDR_W  = 12;
    localparam int unsigned SIRQ_DATA_W  = 32;
    localparam int unsigned SIRQ_EN_OFS  = 'h150;
    localparam int unsigned SIRQ_CLR_OFS = 'h158;
    localparam int unsigned SIRQ_CLR_BIT = 0;

    // Per-cycle clear commands produced by the register port
    typedef struct packed {
        logic clr_req;   // explicit clear write with the clear bit set
        logic touch;     // any other bus access (self-clear trigger)
    } sirq_cmd_t;
endpackage

// File: rtl/sirq_edge_det.sv
// Rising-edge detector, one lane per event line.
// Assumes the event lines are synchronous to clk. The sampling flops are
// deliberately not reset, so a line held high through reset is not seen
// as an edge.
module sirq_edge_det #(
    parameter int unsigned N = 11
)(
    input  logic         clk,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_lane
        // Remember the previous level of this lane
        always_ff @(posedge clk) begin
            lvl_q[g] <= lvl_i[g];
        end
        // A lane rises when it is high now and was low last cycle
        assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
    end
endmodule

// File: rtl/sirq_regs.sv
// Register port: holds the enable register, decodes the clear register
// and reports bus accesses that count as activity for self-clearing.
// Assumes one access per cycle at most; read data is combinational.
module sirq_regs import sirq_pkg::*; #(
    parameter int unsigned N_EVT   = SIRQ_N_EVT,
    parameter int unsigned ADDR_W  = SIRQ_ADDR_W,
    parameter int unsigned DATA_W  = SIRQ_DATA_W,
    parameter int unsigned EN_OFS  = SIRQ_EN_OFS,
    parameter int unsigned CLR_OFS = SIRQ_CLR_OFS,
    parameter int unsigned CLR_BIT = SIRQ_CLR_BIT
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_EVT-1:0]  en_o,
    output sirq_cmd_t         cmd_o
);
    localparam int unsigned PAD_W = DATA_W - N_EVT;
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_OFS);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    logic [N_EVT-1:0] en_q;
    logic             hit_en;
    logic             hit_clr;

    assign hit_en  = (addr == EN_A);
    assign hit_clr = (addr == CLR_A);

    // Enable register update on a write to its offset
    always_ff @(posedge clk) begin
        if (!rst_n)            en_q <= '0;
        else if (wr && hit_en) en_q <= wdata[N_EVT-1:0];
    end

    // Read mux: only the enable register returns data
    always_comb begin
        rdata = '0;
        if (rd && hit_en) rdata = {{PAD_W{1'b0}}, en_q};
    end

    // Clear commands: explicit clear, or activity elsewhere on the bus
    always_comb begin
        cmd_o.clr_req = wr && hit_clr && wdata[CLR_BIT];
        cmd_o.touch   = rd || (wr && !hit_clr);
    end

    assign en_o = en_q;
endmodule

// File: rtl/sirq_pend.sv
// Pending bank: latches allowed event edges and drives the registered
// interrupt. New edges win over any clear in the same cycle.
module sirq_pend import sirq_pkg::*; #(
    parameter int unsigned N = SIRQ_N_EVT
)(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] en_i,
    input  sirq_cmd_t cmd_i,
    output logic      irq_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_d;
    logic         irq_q;

    // Next pending state: drop on any clear, then add allowed edges
    always_comb begin
        pend_d = (cmd_i.clr_req || cmd_i.touch) ? '0 : pend_q;
        pend_d = pend_d | (rise_i & en_i);
    end

    // Pending flags and the registered OR that forms the interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= |pend_d;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/stat_irq_ctrl.sv
// Top: maskable status interrupt controller. Eleven event lines, an
// enable register, a write-only clear register and self-clearing on
// ongoing bus activity. Assumes all inputs are synchronous to clk.
module stat_irq_ctrl import sirq_pkg::*; #(
    parameter int unsigned N_EVT   = SIRQ_N_EVT,
    parameter int unsigned ADDR_W  = SIRQ_ADDR_W,
    parameter int unsigned DATA_W  = SIRQ_DATA_W,
    parameter int unsigned EN_OFS  = SIRQ_EN_OFS,
    parameter int unsigned CLR_OFS = SIRQ_CLR_OFS,
    parameter int unsigned CLR_BIT = SIRQ_CLR_BIT
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [N_EVT-1:0] rise;
    logic [N_EVT-1:0] en_q;
    sirq_cmd_t        cmd;

    sirq_edge_det #(.N(N_EVT)) u_edge (
        .clk    (clk),
        .lvl_i  (evt_i),
        .rise_o (rise)
    );

    sirq_regs #(
        .N_EVT(N_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .EN_OFS(EN_OFS), .CLR_OFS(CLR_OFS), .CLR_BIT(CLR_BIT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .en_o  (en_q),
        .cmd_o (cmd)
    );

    sirq_pend #(.N(N_EVT)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .en_i   (en_q),
        .cmd_i  (cmd),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/sirq_chk.sv
// Checker for stat_irq_ctrl: relates event edges, bus commands and the
// interrupt output across clock edges. Bound to every instance below.
module sirq_chk #(
    parameter int unsigned N_EVT   = 11,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CLR_OFS = 'h158,
    parameter int unsigned CLR_BIT = 0
)(
    input logic              clk,
    input logic              rst_n,
    input logic [N_EVT-1:0]  evt_i,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_EVT-1:0]  en_q,
    input logic              irq_o
);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && en_q == '0));

    // R3
    edge_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_i & ~$past(evt_i) & en_q) |=> irq_o);

    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CLR_A && bus_wdata[CLR_BIT]
         && (evt_i & ~$past(evt_i) & en_q) == '0) |=> !irq_o);

    // R7
    clear_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && bus_wr && !bus_rd && bus_addr == CLR_A && !bus_wdata[CLR_BIT]) |=> irq_o);

    // R9
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || (bus_wr && bus_addr != CLR_A))
         && (evt_i & ~$past(evt_i) & en_q) == '0) |=> !irq_o);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !bus_rd && !bus_wr) |=> irq_o);

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && (evt_i & ~$past(evt_i) & en_q) == '0) |=> !irq_o);

    // R11
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CLR_A) |-> bus_rdata == '0);
endmodule

bind stat_irq_ctrl sirq_chk #(
    .N_EVT(N_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CLR_OFS(CLR_OFS), .CLR_BIT(CLR_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .en_q      (en_q),
    .irq_o     (irq_o)
);

// File: tb/tb_stat_irq_ctrl.sv
// Bench: sweeps every event line against a set of enable masks, then
// drives the clear/self-clear corner cases. Inputs change 1 ns after a
// rising edge; outputs are sampled there too.
module tb_stat_irq_ctrl;
    localparam int N   = 11;
    localparam logic [11:0] A_EN  = 12'h150;
    localparam logic [11:0] A_CLR = 12'h158;
    localparam logic [11:0] A_NUL = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    stat_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        step();
        rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: counts as a failed check and still prints the summary
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        logic [N-1:0] mask;
        repeat (3) step();
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", irq, 0);
        bus_read(A_EN, rv);
        chk("R1 enable", rv, 0);

        // R2: upper write bits discarded
        bus_write(A_EN, 32'hFFFF_FFFF);
        bus_read(A_EN, rv);
        chk("R2 readback", rv, 32'h7FF);

        // R11: clear and unmapped addresses read zero
        bus_read(A_CLR, rv);
        chk("R11 clr read", rv, 0);
        bus_read(A_NUL, rv);
        chk("R11 unmapped read", rv, 0);

        // R3/R4/R6 sweep: every line against every mask
        for (int m = 0; m < 15; m++) begin
            if (m < N)        mask = N'(1) << m;
            else if (m == 11) mask = '0;
            else if (m == 12) mask = '1;
            else if (m == 13) mask = 11'h555;
            else              mask = 11'h2AA;
            bus_write(A_EN, {21'd0, mask});
            bus_read(A_EN, rv);
            chk("R2 mask readback", rv, {21'd0, mask});
            for (int i = 0; i < N; i++) begin
                evt[i] = 1'b1;
                step();
                chk(mask[i] ? "R3 enabled edge" : "R4 masked edge", irq, mask[i]);
                evt[i] = 1'b0;
                step();
                chk("R10 hold after fall", irq, mask[i]);
                bus_write(A_CLR, 32'h1);
                chk("R6 clear", irq, 0);
            end
        end

        bus_write(A_EN, 32'h7FF);

        // R7: bits 1 and 2 of the clear register do nothing
        evt[3] = 1'b1; step(); evt[3] = 1'b0; step();
        bus_write(A_CLR, 32'h6);
        chk("R7 bits 2:1", irq, 1);
        repeat (4) step();
        chk("R10 idle hold", irq, 1);
        bus_write(A_CLR, 32'h7);
        chk("R6 clear with all bits", irq, 0);

        // R8: new edge in the same cycle as a clear write
        evt[0] = 1'b1; step(); evt[0] = 1'b0; step();
        evt[1] = 1'b1;
        bus_write(A_CLR, 32'h1);
        chk("R8 edge beats clear", irq, 1);
        evt[1] = 1'b0;
        bus_write(A_CLR, 32'h1);
        chk("R6 clear after R8", irq, 0);

        // R8: the same line recurring as the clear lands
        evt[5] = 1'b1; step(); evt[5] = 1'b0; step();
        evt[5] = 1'b1;
        bus_write(A_CLR, 32'h1);
        chk("R8 same line recurs", irq, 1);
        evt[5] = 1'b0; step();

        // R9: self-clear by read, after an idle stretch
        repeat (3) step();
        chk("R10 before read", irq, 1);
        bus_read(A_NUL, rv);
        chk("R9 read self-clear", irq, 0);

        // R9: self-clear by a write elsewhere
        evt[7] = 1'b1; step(); evt[7] = 1'b0; step();
        bus_write(A_EN, 32'h7FF);
        chk("R9 write self-clear", irq, 0);

        // R8: edge during a self-clearing read
        evt[2] = 1'b1; step(); evt[2] = 1'b0; step();
        evt[9] = 1'b1;
        bus_read(A_EN, rv);
        chk("R8 edge beats self-clear", irq, 1);
        evt[9] = 1'b0;
        bus_write(A_CLR, 32'h1);
        chk("R6 clear", irq, 0);

        // R5: level held high gives one interrupt only
        evt[4] = 1'b1; step();
        chk("R5 first edge", irq, 1);
        bus_write(A_CLR, 32'h1);
        chk("R5 cleared", irq, 0);
        repeat (5) step();
        chk("R5 held level", irq, 0);
        evt[4] = 1'b0; step();

        // R4: edge while masked, then enabled while still high
        bus_write(A_EN, 32'h0);
        evt[6] = 1'b1; step();
        bus_write(A_EN, 32'h40);
        step(); step();
        chk("R4 late enable", irq, 0);
        evt[6] = 1'b0; step();
        evt[6] = 1'b1; step();
        chk("R3 fresh edge", irq, 1);
        evt[6] = 1'b0; step();

        // R1: reset in mid-interrupt
        rst_n = 1'b0; step();
        rst_n = 1'b1;
        chk("R1 irq after reset", irq, 0);
        bus_read(A_EN, rv);
        chk("R1 enable after reset", rv, 0);

        finish_run();
    end
endmodule